// File: doc/BRIEF.md
# TDM Audio Serial Transmitter

This block is the master-side transmit serializer for a multi-slot audio frame. It runs on the master clock. From that clock it derives a bit clock (`bclk`) and a word-select line (`ws`). It shifts slot samples out most significant bit first on `sdo`, which is suitable for a time-division-multiplexed link to one or more codecs.

The frame has two settings. The active-slot mask sets how many slots the frame carries. A format select picks how `ws` is shaped:

- Half-frame format: `ws` has a 50% duty.
- Long-pulse format: `ws` is high for one slot width per frame.

In both formats the data lags the `ws` boundary by one bit. Samples arrive one slot word at a time over a ready/valid pair. The block asserts `s_ready` for one master-clock cycle per slot and reports, on `s_slot`, which mask position the requested word belongs to.

All configuration is sampled once, when `start` is seen in the idle state. The controller then checks the configuration, derives the bit-clock divider by repeated subtraction, and either runs frames or holds an error flag. The controller is a five-state machine:

- IDLE: all lines low.
- CALC: checks the limits and divides the master-clock multiple by the frame bit count.
- RUN: frames are being sent.
- TAIL: one extra bit period that carries the last delayed data bit.
- FAULT: the configuration was refused.

The transitions are:

- IDLE→CALC when `start` is high.
- CALC→FAULT when a limit is broken or the divide is unusable.
- CALC→RUN when the divider is valid.
- RUN→TAIL at the end of a frame with `start` low.
- TAIL→IDLE after one bit period.
- FAULT→IDLE when `start` is low.

Top module: `tdm_tx`

## Requirements
- R1: After reset and whenever the block is idle, `bclk`, `ws`, `sdo`, `s_ready`, `underrun` and `cfg_err` are all low.
- R2: A configuration with no active slot, or with active slots × slot width above 128 bits, is refused: `cfg_err` goes high one cycle after the check begins, stays high while `start` is high, no bit clock runs, and it clears once `start` is low.
- R3: The divider is `cfg_mult` / (active slots × slot width). If this is not an exact, even integer of at least 2, `cfg_err` is raised and no frame is sent. The check takes floor(quotient)+1 master-clock cycles.
- R4: In the running and tail states, each bit lasts `div` master-clock cycles: `bclk` is low for the first `div`/2 cycles and high for the rest.
- R5: With `cfg_fmt`=0, `ws` is low for the first half of the frame's bit periods and high for the second half.
- R6: With `cfg_fmt`=1, `ws` is high for the first slot-width bit periods of each frame and low for the rest.
- R7: `sdo` carries each slot word MSB first, delayed by one bit period from the frame's first bit. In bit 0 of a frame it carries the previous frame's last bit, or 0 for the first frame. `sdo` and `ws` change only while `bclk` is low.
- R8: A word is requested by a one-cycle `s_ready` pulse in the last master-clock cycle before each slot's first bit. `s_slot` names the mask bit of that slot, in ascending mask order. Only the low slot-width bits of `s_data` are sent.
- R9: If `s_valid` is low when `s_ready` is high, that slot is sent as zeros and `underrun` is high for that single cycle.
- R10: Configuration inputs are captured at start, and changes while running have no effect. Lowering `start` completes the current frame, sends one tail bit period with `ws` low, and then returns to idle.
- R11: `cfg_width` codes 0, 1, 2 and 3 select slot widths of 8, 16, 24 and 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request (level) |
| cfg_fmt | input | 1 | 0 = half-frame `ws`, 1 = one-slot `ws` pulse |
| cfg_width | input | 2 | Slot width code |
| cfg_mask | input | 16 | Active-slot mask |
| cfg_mult | input | MULT_W | Master-clock cycles per frame |
| s_valid | input | 1 | Sample word valid |
| s_data | input | 32 | Sample word, right-aligned |
| s_ready | output | 1 | Sample word taken this cycle |
| s_slot | output | 4 | Mask position of the requested word |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sdo | output | 1 | Serial data |
| underrun | output | 1 | Missing sample pulse |
| cfg_err | output | 1 | Configuration refused |

## Verification
A wrong phase or bit counter shows up on `bclk` or `ws` within one bit period. A corrupted shift register shows up as a wrong `sdo` bit no later than the end of the current slot. A wrong check or divide in the controller shows up at the ports as a misplaced `cfg_err`, or as a first `s_ready` in the wrong cycle, a few cycles after `start`. A fault in the slot iterator appears on `s_slot` at the next request. Because the bench model is compared on every master-clock cycle, each of these faults is reported in the cycle where it first becomes visible.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    localparam int MAX_SLOTS = 16;
    localparam int SAMPLE_W  = 32;
    localparam int SLOT_IW   = $clog2(MAX_SLOTS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALC,
        ST_RUN,
        ST_TAIL,
        ST_FAULT
    } tx_state_e;

    // width code 0..3 -> 8, 16, 24, 32 bits
    function automatic logic [5:0] slot_bits(input logic [1:0] code);
        return 6'({code, 3'b000}) + 6'd8;
    endfunction

    function automatic logic [SLOT_IW:0] count_ones(input logic [MAX_SLOTS-1:0] m);
        logic [SLOT_IW:0] n;
        n = '0;
        for (int i = 0; i < MAX_SLOTS; i++) begin
            n = n + (SLOT_IW+1)'(m[i]);
        end
        return n;
    endfunction

    // next set bit strictly after cur, circular; cur = all ones finds the first
    function automatic logic [SLOT_IW-1:0] next_set(input logic [MAX_SLOTS-1:0] m,
                                                    input logic [SLOT_IW-1:0] cur);
        logic [SLOT_IW-1:0] idx;
        logic [SLOT_IW-1:0] res;
        logic               hit;
        res = cur;
        hit = 1'b0;
        for (int i = 1; i <= MAX_SLOTS; i++) begin
            idx = cur + SLOT_IW'(i);
            if (!hit && m[idx]) begin
                res = idx;
                hit = 1'b1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
    import tdm_tx_pkg::*;
#(
    parameter int MULT_W         = 12,
    parameter int FB_W           = 10,
    parameter int MAX_FRAME_BITS = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 cfg_fmt,
    input  logic [1:0]           cfg_width,
    input  logic [MAX_SLOTS-1:0] cfg_mask,
    input  logic [MULT_W-1:0]    cfg_mult,
    input  logic                 frame_last,
    input  logic                 bit_last,
    input  logic                 slot_next,
    output tx_state_e            state,
    output logic                 fmt_q,
    output logic [5:0]           wbits,
    output logic [FB_W-1:0]      fbits,
    output logic [MAX_SLOTS-1:0] mask_q,
    output logic [MULT_W-1:0]    div_q,
    output logic                 load,
    output logic                 cfg_err
);

    localparam int CW = (MULT_W > FB_W) ? MULT_W + 1 : FB_W + 1;

    tx_state_e          state_nx;
    logic [SLOT_IW:0]   nslots;
    logic [MULT_W-1:0]  rem;
    logic [MULT_W-1:0]  quo;
    logic               limit_bad;
    logic               rem_ge;
    logic               div_ok;

    assign fbits     = FB_W'(nslots) * FB_W'(wbits);
    assign limit_bad = (nslots == '0) || (fbits > FB_W'(MAX_FRAME_BITS));
    assign rem_ge    = CW'(rem) >= CW'(fbits);
    assign div_ok    = (rem == '0) && (quo >= MULT_W'(2)) && !quo[0];
    assign div_q     = quo;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_CALC;
            ST_CALC: begin
                if (limit_bad)   state_nx = ST_FAULT;
                else if (rem_ge) state_nx = ST_CALC;
                else if (div_ok) state_nx = ST_RUN;
                else             state_nx = ST_FAULT;
            end
            ST_RUN:   if (frame_last && !start) state_nx = ST_TAIL;
            ST_TAIL:  if (bit_last) state_nx = ST_IDLE;
            ST_FAULT: if (!start) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // configuration capture and divide-by-subtraction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q  <= 1'b0;
            wbits  <= 6'd8;
            nslots <= '0;
            mask_q <= '0;
            rem    <= '0;
            quo    <= '0;
        end else if (state == ST_IDLE && start) begin
            fmt_q  <= cfg_fmt;
            wbits  <= slot_bits(cfg_width);
            nslots <= count_ones(cfg_mask);
            mask_q <= cfg_mask;
            rem    <= cfg_mult;
            quo    <= '0;
        end else if (state == ST_CALC && !limit_bad && rem_ge) begin
            rem <= rem - MULT_W'(fbits);
            quo <= quo + MULT_W'(1);
        end
    end

    // outputs
    always_comb begin
        load    = 1'b0;
        cfg_err = 1'b0;
        unique case (state)
            ST_CALC:  load = !limit_bad && !rem_ge && div_ok;
            ST_RUN:   load = slot_next && !(frame_last && !start);
            ST_FAULT: cfg_err = 1'b1;
            default:  load = 1'b0;
        endcase
    end

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT && start) |=> (state == ST_FAULT)); // R2

    AST_RUN_DIV_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (div_q >= MULT_W'(2) && !div_q[0])); // R3

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) == ST_RUN) |-> ($stable(wbits) && $stable(mask_q) && $stable(fmt_q))); // R10

endmodule

// File: rtl/tdm_tx_timing.sv
module tdm_tx_timing
    import tdm_tx_pkg::*;
#(
    parameter int MULT_W = 12,
    parameter int FB_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tx_state_e         state,
    input  logic              fmt,
    input  logic [5:0]        wbits,
    input  logic [FB_W-1:0]   fbits,
    input  logic [MULT_W-1:0] div,
    output logic              bclk,
    output logic              ws,
    output logic              bit_last,
    output logic              frame_last,
    output logic              slot_next
);

    logic [MULT_W-1:0] phase;
    logic [FB_W-1:0]   bitn;
    logic [5:0]        sbit;
    logic              active;
    logic              running;

    assign running    = (state == ST_RUN);
    assign active     = running || (state == ST_TAIL);
    assign bit_last   = active && (phase == div - MULT_W'(1));
    assign frame_last = running && bit_last && (bitn == fbits - FB_W'(1));
    assign slot_next  = running && bit_last && (sbit == wbits - 6'd1);

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            phase <= '0;
            bitn  <= '0;
            sbit  <= '0;
        end else if (bit_last) begin
            phase <= '0;
            if (running) begin
                bitn <= frame_last ? '0 : bitn + FB_W'(1);
                sbit <= slot_next ? '0 : sbit + 6'd1;
            end
        end else begin
            phase <= phase + MULT_W'(1);
        end
    end

    always_comb begin
        bclk = active && (phase >= (div >> 1));
        if (!running)  ws = 1'b0;
        else if (fmt)  ws = bitn < FB_W'(wbits);
        else           ws = bitn >= (fbits >> 1);
    end

    AST_WS_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws) |-> !bclk); // R7

    AST_BCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |-> (phase == (div >> 1))); // R4

endmodule

// File: rtl/tdm_tx_shifter.sv
module tdm_tx_shifter
    import tdm_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic                 shift,
    input  logic                 load,
    input  logic                 seed_ch,
    input  logic [5:0]           wbits,
    input  logic [MAX_SLOTS-1:0] mask_q,
    input  logic                 s_valid,
    input  logic [SAMPLE_W-1:0]  s_data,
    output logic                 sdo,
    output logic                 s_ready,
    output logic                 underrun,
    output logic [SLOT_IW-1:0]   s_slot
);

    logic [SAMPLE_W-1:0] shreg;
    logic                dly;
    logic [SLOT_IW-1:0]  ch;
    logic [5:0]          sh_amt;

    assign sh_amt = 6'(SAMPLE_W) - wbits;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            dly   <= 1'b0;
        end else begin
            if (!active)    dly <= 1'b0;
            else if (shift) dly <= shreg[SAMPLE_W-1];
            if (load)       shreg <= s_valid ? (s_data << sh_amt) : '0;
            else if (shift) shreg <= shreg << 1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)               ch <= '0;
        else if (load)            ch <= next_set(mask_q, ch);
        else if (seed_ch)         ch <= next_set(mask_q, '1);
    end

    assign sdo      = active && dly;
    assign s_ready  = load;
    assign underrun = load && !s_valid;
    assign s_slot   = ch;

    AST_ZERO_ON_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> (shreg == '0)); // R9

    AST_SLOT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> mask_q[s_slot]); // R8

endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
    import tdm_tx_pkg::*;
#(
    parameter int MULT_W         = 12,
    parameter int MAX_FRAME_BITS = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 cfg_fmt,
    input  logic [1:0]           cfg_width,
    input  logic [15:0]          cfg_mask,
    input  logic [MULT_W-1:0]    cfg_mult,
    input  logic                 s_valid,
    input  logic [31:0]          s_data,
    output logic                 s_ready,
    output logic [3:0]           s_slot,
    output logic                 bclk,
    output logic                 ws,
    output logic                 sdo,
    output logic                 underrun,
    output logic                 cfg_err
);

    localparam int FB_W = $clog2(MAX_SLOTS * SAMPLE_W + 1);

    tx_state_e              state;
    logic                   fmt_q;
    logic [5:0]             wbits;
    logic [FB_W-1:0]        fbits;
    logic [MAX_SLOTS-1:0]   mask_q;
    logic [MULT_W-1:0]      div_q;
    logic                   load;
    logic                   bit_last;
    logic                   frame_last;
    logic                   slot_next;
    logic                   active;

    assign active = (state == ST_RUN) || (state == ST_TAIL);

    tdm_tx_ctrl #(
        .MULT_W         (MULT_W),
        .FB_W           (FB_W),
        .MAX_FRAME_BITS (MAX_FRAME_BITS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_fmt    (cfg_fmt),
        .cfg_width  (cfg_width),
        .cfg_mask   (cfg_mask),
        .cfg_mult   (cfg_mult),
        .frame_last (frame_last),
        .bit_last   (bit_last),
        .slot_next  (slot_next),
        .state      (state),
        .fmt_q      (fmt_q),
        .wbits      (wbits),
        .fbits      (fbits),
        .mask_q     (mask_q),
        .div_q      (div_q),
        .load       (load),
        .cfg_err    (cfg_err)
    );

    tdm_tx_timing #(
        .MULT_W (MULT_W),
        .FB_W   (FB_W)
    ) u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .fmt        (fmt_q),
        .wbits      (wbits),
        .fbits      (fbits),
        .div        (div_q),
        .bclk       (bclk),
        .ws         (ws),
        .bit_last   (bit_last),
        .frame_last (frame_last),
        .slot_next  (slot_next)
    );

    tdm_tx_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .shift    ((state == ST_RUN) && bit_last),
        .load     (load),
        .seed_ch  (state == ST_CALC),
        .wbits    (wbits),
        .mask_q   (mask_q),
        .s_valid  (s_valid),
        .s_data   (s_data),
        .sdo      (sdo),
        .s_ready  (s_ready),
        .underrun (underrun),
        .s_slot   (s_slot)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!bclk && !ws && !sdo && !s_ready)); // R1

    AST_SDO_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> !bclk); // R7

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!bclk && !ws && !s_ready)); // R2

endmodule

// File: tb/tdm_tx_test.sv
`timescale 1ns/1ps
module tdm_tx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_fmt = 1'b0;
    logic [1:0]  cfg_width = 2'd0;
    logic [15:0] cfg_mask = 16'h0;
    logic [11:0] cfg_mult = 12'd0;
    logic        s_valid;
    logic [31:0] s_data;
    logic        s_ready, bclk, ws, sdo, underrun, cfg_err;
    logic [3:0]  s_slot;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;
    bit done = 0;

    logic [31:0] src_word = 32'h9E37_79B9;
    bit          src_en = 1'b1;
    bit          src_toggle = 1'b0;
    int          tog_cnt = 0;

    assign s_valid = src_en;
    assign s_data  = src_word;

    always #2.5 clk = ~clk;

    tdm_tx uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_fmt(cfg_fmt),
        .cfg_width(cfg_width), .cfg_mask(cfg_mask), .cfg_mult(cfg_mult),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .s_slot(s_slot),
        .bclk(bclk), .ws(ws), .sdo(sdo), .underrun(underrun), .cfg_err(cfg_err)
    );

    // behavioural reference: 0 idle, 1 check, 2 run, 3 tail, 4 refused
    int          m_mode = 0;
    int          m_left, m_div, m_w, m_n, m_fb, m_cyc, m_ldcnt;
    bit          m_fmt, m_ok, m_prev;
    int          chans[16];
    logic [31:0] fw[16];
    string       err_tag = "R2";

    function automatic bit exp_load();
        int ph, b;
        if (m_mode == 1) return (m_left == 1) && m_ok;
        if (m_mode != 2) return 1'b0;
        ph = m_cyc % m_div;
        b  = m_cyc / m_div;
        return (ph == m_div - 1) && (((b + 1) % m_w) == 0) && !(b == m_fb - 1 && !start);
    endfunction

    function automatic int exp_slot_idx();
        int b;
        if (m_mode == 1) return 0;
        b = m_cyc / m_div;
        return ((b + 1) % m_fb) / m_w;
    endfunction

    task automatic do_load(input int k);
        logic [31:0] wm;
        wm = (m_w == 32) ? 32'hFFFF_FFFF : ((32'd1 << m_w) - 32'd1);
        fw[k] = s_valid ? (s_data & wm) : 32'd0;
        m_ldcnt++;
    endtask

    always @(posedge clk) begin
        bit ld;
        int q, ph, b, k;
        if (!rst_n) begin
            m_mode = 0;
        end else begin
            ld = exp_load();
            k  = exp_slot_idx();
            case (m_mode)
                0: if (start) begin
                    m_fmt = cfg_fmt;
                    m_w   = 8 * (int'(cfg_width) + 1);   // R11 width code
                    m_n   = 0;
                    for (int i = 0; i < 16; i++) if (cfg_mask[i]) begin chans[m_n] = i; m_n++; end
                    m_fb  = m_n * m_w;
                    if (m_n == 0 || m_fb > 128) begin
                        m_ok = 0; m_left = 1;
                    end else begin
                        q = int'(cfg_mult) / m_fb;
                        m_ok = (int'(cfg_mult) % m_fb == 0) && q >= 2 && (q % 2 == 0);
                        m_left = q + 1;
                        m_div = q;
                    end
                    m_mode = 1;
                end
                1: begin
                    if (ld) do_load(0);
                    m_left--;
                    if (m_left == 0) begin
                        m_mode = m_ok ? 2 : 4;
                        m_cyc = 0;
                        m_prev = 0;
                    end
                end
                2: begin
                    ph = m_cyc % m_div;
                    b  = m_cyc / m_div;
                    if (ph == m_div - 1 && b == m_fb - 1) begin
                        m_prev = fw[m_n-1][0];
                        m_cyc = 0;
                        if (!start) m_mode = 3;
                    end else begin
                        m_cyc++;
                    end
                    if (ld) do_load(k);
                end
                3: begin
                    m_cyc++;
                    if (m_cyc == m_div) begin m_mode = 0; m_cyc = 0; end
                end
                4: if (!start) m_mode = 0;
                default: m_mode = 0;
            endcase
        end
    end

    // source: advance word on each accepted transfer, optional valid toggling
    initial begin
        forever begin
            @(posedge clk);
            if (s_ready && s_valid)
                src_word <= {src_word[30:0], src_word[31] ^ src_word[21] ^ src_word[1] ^ src_word[0]};
            if (src_toggle) begin
                tog_cnt = tog_cnt + 1;
                if (tog_cnt % 23 == 0) src_en <= ~src_en;
            end
        end
    end

    task automatic chk(input bit got, input bit exp, input string tag, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: %s got %0d expected %0d at cycle %0d", tag, what, got, exp, cycles);
        end
    endtask

    task automatic chk_int(input int got, input int exp, input string tag, input string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // compare on every cycle away from the edge
    always @(negedge clk) begin
        bit e_bclk, e_ws, e_sdo, e_ld;
        int ph, b, bb;
        if (started && !done) begin
            e_bclk = 0; e_ws = 0; e_sdo = 0;
            if (m_mode == 2) begin
                ph = m_cyc % m_div;
                b  = m_cyc / m_div;
                e_bclk = ph >= m_div / 2;
                e_ws   = m_fmt ? (b < m_w) : (b >= m_fb / 2);
                if (b == 0) e_sdo = m_prev;
                else begin
                    bb = b - 1;
                    e_sdo = fw[bb / m_w][m_w - 1 - (bb % m_w)];
                end
            end else if (m_mode == 3) begin
                e_bclk = m_cyc >= m_div / 2;
                e_sdo  = m_prev;
            end
            e_ld = exp_load();
            chk(bclk, e_bclk, (m_mode == 0) ? "R1" : "R4", "bclk");
            chk(ws, e_ws, (m_mode == 0) ? "R1" : (m_fmt ? "R6" : "R5"), "ws");
            chk(sdo, e_sdo, (m_mode == 0) ? "R1" : "R7", "sdo");
            chk(s_ready, e_ld, "R8", "s_ready");
            chk(underrun, e_ld && !s_valid, "R9", "underrun");
            chk(cfg_err, m_mode == 4, err_tag, "cfg_err");
            if (e_ld) chk_int(int'(s_slot), chans[exp_slot_idx()], "R8", "s_slot");
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_mode(input int md);
        while (m_mode != md) step();
    endtask

    task automatic run_frames(input bit f, input logic [1:0] wc, input logic [15:0] mk,
                              input int mult, input int frames, input bit scramble);
        cfg_fmt = f; cfg_width = wc; cfg_mask = mk; cfg_mult = 12'(mult);
        m_ldcnt = 0;
        start = 1;
        wait_mode(2);
        if (scramble) begin   // R10: inputs changed mid-run must not matter
            cfg_fmt = ~f; cfg_width = wc + 2'd1; cfg_mask = ~mk; cfg_mult = 12'(mult + 8);
        end
        repeat ((frames - 1) * m_fb * m_div + 2) step();
        start = 0;
        wait_mode(0);
        step();
        chk_int(m_ldcnt, frames * m_n, "R10", "words taken over the run");
        chk(bclk | ws | sdo, 1'b0, "R10", "lines low after stop");
    endtask

    task automatic run_fault(input string tag, input logic [1:0] wc, input logic [15:0] mk,
                             input int mult);
        err_tag = tag;
        cfg_fmt = 0; cfg_width = wc; cfg_mask = mk; cfg_mult = 12'(mult);
        start = 1;
        wait_mode(4);
        repeat (3) step();
        chk(cfg_err, 1'b1, tag, "refusal held while start high");
        start = 0;
        step(); step();
        chk(cfg_err, 1'b0, tag, "refusal cleared after start low");
        err_tag = "R2";
    endtask

    initial begin
        repeat (4) step();
        started = 1;
        repeat (2) step();
        rst_n = 1;
        repeat (8) step();
        chk(bclk | ws | sdo | s_ready | cfg_err, 1'b0, "R1", "idle outputs after reset");

        // R5 R11: half-frame, 16-bit, two slots, div 2, with mid-run config changes
        run_frames(1'b0, 2'd1, 16'h0003, 64, 3, 1'b1);
        // R6 R8: long pulse, 8-bit, five scattered slots, div 4
        run_frames(1'b1, 2'd0, 16'h0A51, 160, 2, 1'b0);
        // R11: 24-bit, five slots (120 bits), div 2
        run_frames(1'b0, 2'd2, 16'h001F, 240, 2, 1'b0);
        // R9: 32-bit single slot at the top of the mask, source empty
        src_en = 0;
        run_frames(1'b1, 2'd3, 16'h8000, 128, 2, 1'b0);
        src_en = 1;
        // R9: 32-bit four slots, source toggling
        src_toggle = 1;
        run_frames(1'b0, 2'd3, 16'hF000, 256, 3, 1'b0);
        src_toggle = 0;
        src_en = 1;
        // R4: larger divider, 16-bit eight slots, div 6
        run_frames(1'b1, 2'd1, 16'hFF00, 768, 1, 1'b0);

        run_fault("R2", 2'd3, 16'h001F, 512);   // 5 x 32 bits exceeds the limit
        run_fault("R2", 2'd1, 16'h0000, 256);   // no active slot
        run_fault("R3", 2'd0, 16'h0003, 48);    // quotient 3 is odd
        run_fault("R3", 2'd0, 16'h0003, 50);    // not an exact multiple
        run_fault("R3", 2'd0, 16'h0003, 16);    // quotient 1 is below 2

        // R10: restart after refusals works normally
        run_frames(1'b1, 2'd0, 16'h0101, 64, 2, 1'b0);

        repeat (5) step();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule